// File: doc/BRIEF.md
# Carrier Loop Filter with Frequency-Assisted Phase Tracking

This block is the loop filter of a carrier tracking channel. Each update strobe brings two signed discriminator outputs: a frequency error and a phase error. It turns them into one frequency command for the carrier numerically controlled oscillator. The phase path is a third-order filter and the frequency path is a second-order filter. Both share a chain of two trapezoidal integrators: an acceleration accumulator followed by a velocity accumulator. The frequency-error terms enter one integration stage ahead of the phase-error terms of the same order, because a frequency error is the rate of a phase error. The last integration, from frequency to phase, is left to the oscillator.

The block has three operating modes: frequency-only, assisted (both errors), and phase-only. A mode is made by forcing the unused error to zero before it reaches the gains. Software either forces a mode or leaves the block on automatic sequencing. Automatic sequencing starts in frequency-only mode, moves to assisted mode on a frequency-lock indication and to phase-only mode on a phase-lock indication, and drops back to frequency-only mode on loss of lock. All five gains arrive already computed, as unsigned fixed-point values with `GF` fraction bits. Both accumulators can be loaded with bias values at the moment external aiding is injected. Every stored or output value saturates instead of wrapping.

Top module: `carrier_loop_filter`

## Requirements
- R1: While `rst` is high at a clock edge, both accumulators, `nco_freq` and `nco_valid` are cleared and the automatic sequencer returns to frequency-only mode.
- R2: `mode_sel` codes: 0 = automatic, 1 = frequency-only, 2 = assisted, 3 = phase-only. `loop_mode` shows the active mode: 0 = frequency-only, 1 = assisted, 2 = phase-only. In frequency-only mode `phase_err` has no effect. In phase-only mode `freq_err` has no effect.
- R3: In automatic mode the sequencer moves from frequency-only to assisted when `freq_lock` is high at an edge, and from assisted to phase-only when `phase_lock` is high. `phase_lock` has no effect in frequency-only mode.
- R4: `lock_lost` high at an edge sends the sequencer to frequency-only mode from any state. It takes priority over both lock inputs.
- R5: On an update, the acceleration accumulator adds x1 = (ef·`g_f2` + ep·`g_p3`) >>> GF, where ef and ep are the errors after mode gating.
- R6: On the same update, the velocity accumulator adds x2 = (amid >>> TS) + ((ef·`g_f1` + ep·`g_p2`) >>> GF). Here amid = sat(old acceleration + (x1 >>> 1)) is the trapezoidal midpoint.
- R7: On an update, `nco_freq` becomes sat(vmid + ((ep·`g_p1`) >>> GF)), where vmid = sat(old velocity + (x2 >>> 1)). `nco_valid` is high for exactly the one cycle after each update that took effect.
- R8: Without `upd` or `bias_load`, the accumulators and `nco_freq` hold their values whatever the error inputs do.
- R9: `bias_load` writes `accel_bias` and `vel_bias` into the accumulators at the edge. It overrides an update in the same cycle, and it leaves `nco_freq` unchanged with `nco_valid` low.
- R10: Accumulators and `nco_freq` saturate to the range −2^(AW−1) … 2^(AW−1)−1 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Mode select: 0 auto, 1 frequency-only, 2 assisted, 3 phase-only |
| freq_lock | input | 1 | Frequency lock indication |
| phase_lock | input | 1 | Phase lock indication |
| lock_lost | input | 1 | Loss-of-lock indication |
| upd | input | 1 | Update strobe for one loop iteration |
| freq_err | input | EW | Signed frequency discriminator output |
| phase_err | input | EW | Signed phase discriminator output |
| g_f2 | input | GW | Frequency gain into acceleration stage |
| g_f1 | input | GW | Frequency gain into velocity stage |
| g_p3 | input | GW | Phase gain into acceleration stage |
| g_p2 | input | GW | Phase gain into velocity stage |
| g_p1 | input | GW | Phase gain added at the output |
| bias_load | input | 1 | Load both accumulators with bias values |
| accel_bias | input | AW | Signed acceleration bias value |
| vel_bias | input | AW | Signed velocity bias value |
| nco_freq | output | AW | Signed frequency command to the oscillator |
| nco_valid | output | 1 | One-cycle pulse after each update |
| accel_est | output | AW | Acceleration accumulator contents |
| vel_est | output | AW | Velocity accumulator contents |
| loop_mode | output | 2 | Active mode: 0 frequency, 1 assisted, 2 phase |

## Verification
The bench compares the outputs after every update with an arithmetic model of the requirements. It looks for the cases that are easy to get wrong. If the frequency gains were wired into the wrong stage, or the trapezoidal half-step were missing, `vel_est` and `nco_freq` would drift from the model within one update. Both single-error modes are started from cleared accumulators and given a large error only on the gated input. A gate that leaked would show up as a nonzero output. The bench also drives a load and an update in the same cycle, pushes both accumulators past their positive and negative limits, and sends the sequencer conflicting lock inputs. A design that wrapped, let the update win, or let phase lock skip the assisted state would show a wrong sign, a changed `nco_freq`, or a wrong `loop_mode`.

// File: rtl/clf_pkg.sv
package clf_pkg;

    typedef enum logic [1:0] {
        LM_FREQ   = 2'd0,
        LM_ASSIST = 2'd1,
        LM_PHASE  = 2'd2
    } loop_mode_e;

    localparam logic [1:0] SEL_AUTO   = 2'd0;
    localparam logic [1:0] SEL_FREQ   = 2'd1;
    localparam logic [1:0] SEL_ASSIST = 2'd2;

    // Map a forced select code to a loop mode (code 0 is handled by caller).
    function automatic loop_mode_e forced_mode(input logic [1:0] sel);
        case (sel)
            SEL_FREQ:   return LM_FREQ;
            SEL_ASSIST: return LM_ASSIST;
            default:    return LM_PHASE;
        endcase
    endfunction

endpackage

// File: rtl/clf_sat.sv
module clf_sat #(
    parameter int IW = 35,
    parameter int OW = 32
) (
    input  logic signed [IW-1:0] din,
    output logic signed [OW-1:0] dout
);
    localparam logic signed [IW-1:0] SMAX = $signed({{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}});
    localparam logic signed [IW-1:0] SMIN = $signed({{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}});

    always_comb begin
        if (din > SMAX)      dout = SMAX[OW-1:0];
        else if (din < SMIN) dout = SMIN[OW-1:0];
        else                 dout = din[OW-1:0];
    end
endmodule

// File: rtl/clf_gain_pair.sv
module clf_gain_pair #(
    parameter int EW = 16,
    parameter int GW = 16,
    parameter int GF = 12,
    parameter int XW = 35
) (
    input  logic signed [EW-1:0] e0,
    input  logic        [GW-1:0] g0,
    input  logic signed [EW-1:0] e1,
    input  logic        [GW-1:0] g1,
    output logic signed [XW-1:0] y
);
    localparam int PW = EW + GW + 1;

    logic signed [PW-1:0] e0x, e1x, g0x, g1x, p0, p1;
    logic signed [PW:0]   sum, shf;

    always_comb begin
        e0x = $signed({{(PW-EW){e0[EW-1]}}, e0});
        e1x = $signed({{(PW-EW){e1[EW-1]}}, e1});
        g0x = $signed({{(PW-GW){1'b0}}, g0});
        g1x = $signed({{(PW-GW){1'b0}}, g1});
        p0  = e0x * g0x;
        p1  = e1x * g1x;
        sum = $signed({p0[PW-1], p0}) + $signed({p1[PW-1], p1});
        shf = sum >>> GF;
        y   = $signed({{(XW-PW-1){shf[PW]}}, shf});
    end
endmodule

// File: rtl/clf_trap_integ.sv
module clf_trap_integ #(
    parameter int AW = 32,
    parameter int XW = 35
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic                 load,
    input  logic signed [AW-1:0] load_val,
    input  logic signed [XW-1:0] x,
    output logic signed [AW-1:0] acc,
    output logic signed [AW-1:0] mid
);
    logic signed [XW-1:0] acc_x, sum_w, half_w;
    logic signed [AW-1:0] sum_sat;

    always_comb begin
        acc_x  = $signed({{(XW-AW){acc[AW-1]}}, acc});
        sum_w  = acc_x + x;
        half_w = acc_x + (x >>> 1);
    end

    clf_sat #(.IW(XW), .OW(AW)) u_sat_sum (.din(sum_w),  .dout(sum_sat));
    clf_sat #(.IW(XW), .OW(AW)) u_sat_mid (.din(half_w), .dout(mid));

    always_ff @(posedge clk) begin
        if (rst)       acc <= '0;
        else if (load) acc <= load_val;
        else if (step) acc <= sum_sat;
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) rst |=> acc == '0);
    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(acc));
    // R9
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> acc == $past(load_val));
    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !x[XW-1]) |=> $signed(acc) >= $signed($past(acc)));
endmodule

// File: rtl/clf_mode_ctrl.sv
module clf_mode_ctrl
    import clf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       freq_lock,
    input  logic       phase_lock,
    input  logic       lock_lost,
    output loop_mode_e mode_o
);
    loop_mode_e st, st_nx;

    always_comb begin
        st_nx = st;
        if (lock_lost) st_nx = LM_FREQ;
        else begin
            case (st)
                LM_FREQ:   if (freq_lock)  st_nx = LM_ASSIST;
                LM_ASSIST: if (phase_lock) st_nx = LM_PHASE;
                LM_PHASE:  st_nx = LM_PHASE;
                default:   st_nx = LM_FREQ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= LM_FREQ;
        else     st <= st_nx;
    end

    assign mode_o = (mode_sel == SEL_AUTO) ? st : forced_mode(mode_sel);

    // R4
    lost_to_freq_chk: assert property (@(posedge clk) disable iff (rst)
        lock_lost |=> st == LM_FREQ);
    // R3
    no_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (st == LM_FREQ && !freq_lock) |=> st == LM_FREQ);
    // R1
    seq_reset_chk: assert property (@(posedge clk) rst |=> st == LM_FREQ);
endmodule

// File: rtl/carrier_loop_filter.sv
module carrier_loop_filter
    import clf_pkg::*;
#(
    parameter int EW = 16,
    parameter int GW = 16,
    parameter int GF = 12,
    parameter int AW = 32,
    parameter int TS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode_sel,
    input  logic                 freq_lock,
    input  logic                 phase_lock,
    input  logic                 lock_lost,
    input  logic                 upd,
    input  logic signed [EW-1:0] freq_err,
    input  logic signed [EW-1:0] phase_err,
    input  logic [GW-1:0]        g_f2,
    input  logic [GW-1:0]        g_f1,
    input  logic [GW-1:0]        g_p3,
    input  logic [GW-1:0]        g_p2,
    input  logic [GW-1:0]        g_p1,
    input  logic                 bias_load,
    input  logic signed [AW-1:0] accel_bias,
    input  logic signed [AW-1:0] vel_bias,
    output logic signed [AW-1:0] nco_freq,
    output logic                 nco_valid,
    output logic signed [AW-1:0] accel_est,
    output logic signed [AW-1:0] vel_est,
    output logic [1:0]           loop_mode
);
    localparam int XW = AW + 3;

    loop_mode_e           mode;
    logic signed [EW-1:0] ef_g, ep_g;
    logic signed [XW-1:0] x_acc, x_vel_gain, x_vel, x_out, nco_w;
    logic signed [AW-1:0] a_mid, v_mid, a_sh, nco_nx;
    logic                 step;

    clf_mode_ctrl u_mode (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .freq_lock(freq_lock),
        .phase_lock(phase_lock), .lock_lost(lock_lost), .mode_o(mode)
    );
    assign loop_mode = mode;

    // Mode gating: the unused discriminator is forced to zero.
    assign ef_g = (mode == LM_PHASE) ? '0 : freq_err;
    assign ep_g = (mode == LM_FREQ)  ? '0 : phase_err;
    assign step = upd && !bias_load;

    // Acceleration stage: frequency gain enters here, one stage ahead.
    clf_gain_pair #(.EW(EW), .GW(GW), .GF(GF), .XW(XW)) u_g_acc (
        .e0(ef_g), .g0(g_f2), .e1(ep_g), .g1(g_p3), .y(x_acc)
    );
    clf_trap_integ #(.AW(AW), .XW(XW)) u_acc (
        .clk(clk), .rst(rst), .step(step), .load(bias_load),
        .load_val(accel_bias), .x(x_acc), .acc(accel_est), .mid(a_mid)
    );

    // Velocity stage.
    clf_gain_pair #(.EW(EW), .GW(GW), .GF(GF), .XW(XW)) u_g_vel (
        .e0(ef_g), .g0(g_f1), .e1(ep_g), .g1(g_p2), .y(x_vel_gain)
    );
    assign a_sh  = a_mid >>> TS;
    assign x_vel = x_vel_gain + $signed({{(XW-AW){a_sh[AW-1]}}, a_sh});
    clf_trap_integ #(.AW(AW), .XW(XW)) u_vel (
        .clk(clk), .rst(rst), .step(step), .load(bias_load),
        .load_val(vel_bias), .x(x_vel), .acc(vel_est), .mid(v_mid)
    );

    // Output: proportional phase term on top of the velocity midpoint.
    clf_gain_pair #(.EW(EW), .GW(GW), .GF(GF), .XW(XW)) u_g_out (
        .e0(ep_g), .g0(g_p1), .e1('0), .g1('0), .y(x_out)
    );
    assign nco_w = $signed({{(XW-AW){v_mid[AW-1]}}, v_mid}) + x_out;
    clf_sat #(.IW(XW), .OW(AW)) u_sat_out (.din(nco_w), .dout(nco_nx));

    always_ff @(posedge clk) begin
        if (rst) begin
            nco_freq  <= '0;
            nco_valid <= 1'b0;
        end else begin
            nco_valid <= step;
            if (step) nco_freq <= nco_nx;
        end
    end

    // R7
    nco_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && !bias_load) |=> nco_valid);
    // R9
    load_keeps_out_chk: assert property (@(posedge clk) disable iff (rst)
        bias_load |=> ($stable(nco_freq) && !nco_valid));
    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(nco_freq));
endmodule

// File: tb/carrier_loop_filter_tb.sv
`timescale 1ns/1ps
module carrier_loop_filter_tb;
    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    logic clk = 0;
    always #2.5 clk = ~clk;

    logic rst, freq_lock, phase_lock, lock_lost, upd, bias_load;
    logic [1:0] mode_sel;
    logic signed [15:0] freq_err, phase_err;
    logic [15:0] g_f2, g_f1, g_p3, g_p2, g_p1;
    logic signed [31:0] accel_bias, vel_bias, nco_freq, accel_est, vel_est;
    logic nco_valid;
    logic [1:0] loop_mode;

    carrier_loop_filter u_dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .freq_lock(freq_lock),
        .phase_lock(phase_lock), .lock_lost(lock_lost), .upd(upd),
        .freq_err(freq_err), .phase_err(phase_err), .g_f2(g_f2), .g_f1(g_f1),
        .g_p3(g_p3), .g_p2(g_p2), .g_p1(g_p1), .bias_load(bias_load),
        .accel_bias(accel_bias), .vel_bias(vel_bias), .nco_freq(nco_freq),
        .nco_valid(nco_valid), .accel_est(accel_est), .vel_est(vel_est),
        .loop_mode(loop_mode)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    longint ma = 0, mv = 0, mn = 0;

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat(longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    // Reference of R5..R7 from the stated equations (mode 0 freq, 1 assisted, 2 phase).
    task automatic model_step(int md, longint ef, longint ep);
        longint efg, epg, x1, x2, amid, vmid;
        efg  = (md == 2) ? 0 : ef;
        epg  = (md == 0) ? 0 : ep;
        x1   = (efg * longint'(g_f2) + epg * longint'(g_p3)) >>> 12;
        amid = sat(ma + (x1 >>> 1));
        ma   = sat(ma + x1);
        x2   = (amid >>> 4) + ((efg * longint'(g_f1) + epg * longint'(g_p2)) >>> 12);
        vmid = sat(mv + (x2 >>> 1));
        mv   = sat(mv + x2);
        mn   = sat(vmid + ((epg * longint'(g_p1)) >>> 12));
    endtask

    task automatic do_update(int md, int ef, int ep, string req);
        @(negedge clk);
        freq_err = 16'(ef); phase_err = 16'(ep); upd = 1;
        @(negedge clk);
        upd = 0;
        model_step(md, ef, ep);
        chk({req, " nco_freq"}, nco_freq, mn);
        chk({req, " accel_est"}, accel_est, ma);
        chk({req, " vel_est"}, vel_est, mv);
        chk("R7 nco_valid", nco_valid, 1);
    endtask

    task automatic do_load(longint a, longint v);
        @(negedge clk);
        accel_bias = 32'(a); vel_bias = 32'(v); bias_load = 1;
        @(negedge clk);
        bias_load = 0;
        ma = a; mv = v;
    endtask

    task automatic t_reset();
        chk("R1 nco_freq", nco_freq, 0);
        chk("R1 accel_est", accel_est, 0);
        chk("R1 vel_est", vel_est, 0);
        chk("R1 nco_valid", nco_valid, 0);
        chk("R1 loop_mode", loop_mode, 0);
    endtask

    task automatic t_phase_only();
        mode_sel = 2'd3;
        @(negedge clk);
        chk("R2 loop_mode phase", loop_mode, 2);
        do_update(2, 500, 1000, "R5 R6 R7 phase");
        do_update(2, -300, -200, "R5 R6 R7 phase neg");
        do_load(0, 0);
        do_update(2, 9000, 0, "R2 freq ignored");
        chk("R2 freq ignored out", nco_freq, 0);
    endtask

    task automatic t_freq_only();
        mode_sel = 2'd1;
        do_load(0, 0);
        do_update(0, 4000, 0, "R2 freq only");
        do_load(0, 0);
        do_update(0, 0, 9000, "R2 phase ignored");
        chk("R2 phase ignored out", nco_freq, 0);
        do_update(0, -2500, 7000, "R5 R6 freq gated");
    endtask

    task automatic t_assisted();
        mode_sel = 2'd2;
        @(negedge clk);
        chk("R2 loop_mode assist", loop_mode, 1);
        do_update(1, 1200, -800, "R5 R6 R7 assist a");
        do_update(1, -700, 1500, "R5 R6 R7 assist b");
        do_update(1, 32767, -32768, "R5 R6 R7 assist extremes");
    endtask

    task automatic t_hold();
        longint n0, a0, v0;
        n0 = nco_freq; a0 = accel_est; v0 = vel_est;
        @(negedge clk);
        freq_err = 16'sd12345; phase_err = -16'sd9876;
        repeat (3) @(negedge clk);
        chk("R8 hold nco", nco_freq, n0);
        chk("R8 hold accel", accel_est, a0);
        chk("R8 hold vel", vel_est, v0);
        chk("R8 no valid", nco_valid, 0);
    endtask

    task automatic t_load();
        longint n0;
        n0 = nco_freq;
        @(negedge clk);
        accel_bias = 32'sd70000; vel_bias = -32'sd150000;
        bias_load = 1; upd = 1; phase_err = 16'sd3000; freq_err = 16'sd3000;
        @(negedge clk);
        bias_load = 0; upd = 0;
        ma = 70000; mv = -150000;
        chk("R9 accel loaded", accel_est, 70000);
        chk("R9 vel loaded", vel_est, -150000);
        chk("R9 nco unchanged", nco_freq, n0);
        chk("R9 no valid", nco_valid, 0);
        do_update(1, 100, 200, "R9 update after load");
    endtask

    task automatic t_saturate();
        mode_sel = 2'd3;
        do_load(64'sd2147483000, 64'sd2147400000);
        do_update(2, 0, 30000, "R10 positive");
        chk("R10 accel max", accel_est, SMAX);
        chk("R10 nco max", nco_freq, SMAX);
        do_load(-64'sd2147483000, -64'sd2147400000);
        do_update(2, 0, -30000, "R10 negative");
        chk("R10 accel min", accel_est, SMIN);
        chk("R10 vel min", vel_est, SMIN);
    endtask

    task automatic pulse(bit fl, bit pl, bit ll);
        @(negedge clk);
        freq_lock = fl; phase_lock = pl; lock_lost = ll;
        @(negedge clk);
        freq_lock = 0; phase_lock = 0; lock_lost = 0;
    endtask

    task automatic t_auto();
        mode_sel = 2'd0;
        @(negedge clk);
        chk("R3 auto start freq", loop_mode, 0);
        pulse(0, 1, 0);
        chk("R3 phase lock ignored in freq", loop_mode, 0);
        pulse(1, 0, 0);
        chk("R3 to assisted", loop_mode, 1);
        pulse(0, 1, 0);
        chk("R3 to phase", loop_mode, 2);
        pulse(1, 0, 0);
        chk("R3 phase stays", loop_mode, 2);
        pulse(0, 0, 1);
        chk("R4 lost to freq", loop_mode, 0);
        pulse(1, 0, 0);
        pulse(0, 1, 1);
        chk("R4 lost wins", loop_mode, 0);
        do_load(0, 0);
        do_update(0, 0, 8000, "R2 auto freq gates phase");
    endtask

    initial begin
        rst = 1; mode_sel = 0; freq_lock = 0; phase_lock = 0; lock_lost = 0;
        upd = 0; bias_load = 0; freq_err = 0; phase_err = 0;
        accel_bias = 0; vel_bias = 0;
        g_f2 = 16'd2048; g_f1 = 16'd8192; g_p3 = 16'd4096; g_p2 = 16'd6144; g_p1 = 16'd10240;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_phase_only();
        t_freq_only();
        t_assisted();
        t_hold();
        t_load();
        t_saturate();
        t_auto();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #200000ns;
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule